// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 131,072 eight-bit words. The host raises a request with a direction flag, an address and write data. The block turns that request into a sequence of strobe phases on the memory side: a select pair made of one active-low enable and one active-high enable, an active-low output enable and an active-low write enable. It returns read data together with a single-cycle completion pulse.

Each phase is held for a whole number of clock cycles. That number is derived at elaboration from a nanosecond minimum and the clock period: the ceiling of the quotient, and never less than one. Slower memory grades, such as a 70 ns cycle with a 55 ns write pulse and 30 ns data setup, are therefore selected only by changing parameters.

The data bus is presented as separate output, input and drive-enable signals, so the tri-state buffer can sit at the pad. Every strobe and the drive enable leave the block straight from flip-flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the low-active select is 1, the high-active select is 0, output enable and write enable are both 1 (inactive), the data drive enable is 0, and busy is 0.
- R2: A request is taken only on a clock edge where req is 1 and busy is 0. Busy is 1 from the following cycle until the completion pulse. A req raised while busy is ignored: it causes no extra completion and no memory write.
- R3: A read holds the memory selected, with write enable 1 and output enable 0, for exactly max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles. That is 6 cycles at the defaults of an 8 ns clock and 45/45/20 ns. The data input is captured on the last edge of that window.
- R4: Write enable is 0 only while the memory is selected and output enable is 1. Each write-enable-low pulse lasts exactly max(ceil(tWP), HZ + DS) cycles, where HZ = ceil(15 ns) = 2 and DS = ceil(25 ns) = 4 at the defaults. The pulse is therefore 6 cycles.
- R5: The data drive enable rises exactly HZ cycles after write enable falls. It falls on the same edge that write enable rises, and it is never 1 while output enable is 0.
- R6: The memory address stays constant for the whole of every write-enable-low pulse. The write data stays constant while it is driven.
- R7: Between any two accesses the memory is deselected for at least one cycle. After a read, the deselected time lasts HZ cycles.
- R8: The completion pulse is exactly one cycle long. It comes 8 cycles after the busy rise for a read and 9 cycles after it for a write at the default parameters. For a read, the read data output holds the captured byte while the pulse is high.
- R9: Every window length equals the ceiling of its nanosecond minimum divided by the clock period, with a floor of one cycle. The write recovery window is the write cycle count minus the pulse and the select cycle, and at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled while busy is 0 |
| we_req | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host word address |
| wdata | input | 8 | Host write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data to drive onto the memory bus |
| mem_dq_drive | output | 1 | Drive enable for the data pad buffer |
| mem_dq_in | input | 8 | Data sampled from the memory bus |

## Verification
The bench exercises the sequencer with several patterns:
- Isolated writes and reads at the lowest and highest addresses, with all-zero, all-one and alternating-bit bytes. These separate address and data wiring faults.
- A sequential block of writes followed by read-back. This exposes address-latching slips between accesses.
- Back-to-back read-after-write and overwrite-then-read pairs. These expose missing deselect gaps and stale capture.
- A request held high during a busy write. Its address is read back afterwards, which separates a correct ignore from a spurious extra access.

The memory model returns a poison byte until its access time has passed, so a capture one cycle early is caught. Pulse, drive-delay and read-window lengths are measured on the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSEL,
        ST_WHZ,
        ST_WDAT,
        ST_WREC,
        ST_DESEL
    } st_e;

    typedef struct packed {
        st_e  st;
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drv;
        logic done;
    } ctrl_s;

    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_cnt.sv
module sram_win_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
    import sram_ctrl_pkg::*;
(
    input  st_e  st,
    output logic sel_n,
    output logic sel,
    output logic oe_n,
    output logic we_n,
    output logic drv
);
    always_comb begin
        sel_n = 1'b1;
        sel   = 1'b0;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        drv   = 1'b0;
        unique case (st)
            ST_RD: begin
                sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0;
            end
            ST_WSEL, ST_WREC: begin
                sel_n = 1'b0; sel = 1'b1;
            end
            ST_WHZ: begin
                sel_n = 1'b0; sel = 1'b1; we_n = 1'b0;
            end
            ST_WDAT: begin
                sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; drv = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int CW       = 3,
    parameter int RD_CYC   = 6,
    parameter int HZ_CYC   = 2,
    parameter int DATA_CYC = 4,
    parameter int REC_CYC  = 1,
    parameter int TURN_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we_req,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dq_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_out,
    output logic          sel_n,
    output logic          sel,
    output logic          oe_n,
    output logic          we_n,
    output logic          drv
);
    localparam ctrl_s CTRL_RST = '{st: ST_IDLE, sel_n: 1'b1, sel: 1'b0,
                                   oe_n: 1'b1, we_n: 1'b1, drv: 1'b0, done: 1'b0};

    ctrl_s         c_d, c_q;
    logic [AW-1:0] addr_d, addr_q;
    logic [DW-1:0] wdata_d, wdata_q;
    logic [DW-1:0] rdata_d, rdata_q;
    logic          load;
    logic [CW-1:0] load_val;
    logic          last;
    logic          n_sel_n, n_sel, n_oe_n, n_we_n, n_drv;

    sram_win_cnt #(.CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    sram_strobe_dec u_dec (
        .st    (c_d.st),
        .sel_n (n_sel_n),
        .sel   (n_sel),
        .oe_n  (n_oe_n),
        .we_n  (n_we_n),
        .drv   (n_drv)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        addr_d   = addr_q;
        wdata_d  = wdata_q;
        rdata_d  = rdata_q;
        load     = 1'b0;
        load_val = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req) begin
                    addr_d  = addr;
                    wdata_d = wdata;
                    load    = 1'b1;
                    if (we_req) begin
                        c_d.st   = ST_WSEL;
                        load_val = CW'(1);
                    end else begin
                        c_d.st   = ST_RD;
                        load_val = CW'(RD_CYC);
                    end
                end
            end
            ST_RD: begin
                if (last) begin
                    rdata_d  = dq_in;
                    c_d.st   = ST_DESEL;
                    load     = 1'b1;
                    load_val = CW'(TURN_CYC);
                end
            end
            ST_WSEL: begin
                if (last) begin
                    c_d.st   = ST_WHZ;
                    load     = 1'b1;
                    load_val = CW'(HZ_CYC);
                end
            end
            ST_WHZ: begin
                if (last) begin
                    c_d.st   = ST_WDAT;
                    load     = 1'b1;
                    load_val = CW'(DATA_CYC);
                end
            end
            ST_WDAT: begin
                if (last) begin
                    c_d.st   = ST_WREC;
                    load     = 1'b1;
                    load_val = CW'(REC_CYC);
                end
            end
            ST_WREC: begin
                if (last) begin
                    c_d.st   = ST_DESEL;
                    load     = 1'b1;
                    load_val = CW'(1);
                end
            end
            ST_DESEL: begin
                if (last) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        c_d.sel_n = n_sel_n;
        c_d.sel   = n_sel;
        c_d.oe_n  = n_oe_n;
        c_d.we_n  = n_we_n;
        c_d.drv   = n_drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= CTRL_RST;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            c_q     <= c_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            rdata_q <= rdata_d;
        end
    end

    assign busy     = (c_q.st != ST_IDLE);
    assign done     = c_q.done;
    assign rdata    = rdata_q;
    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign sel_n    = c_q.sel_n;
    assign sel      = c_q.sel;
    assign oe_n     = c_q.oe_n;
    assign we_n     = c_q.we_n;
    assign drv      = c_q.drv;

    // R8: completion only follows the deselect window
    assert_done_after_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.done) |-> $past(c_q.st) == ST_DESEL);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int CLK_NS   = 8,
    parameter int T_RC_NS  = 45,
    parameter int T_AA_NS  = 45,
    parameter int T_DOE_NS = 20,
    parameter int T_WC_NS  = 45,
    parameter int T_WP_NS  = 35,
    parameter int T_DS_NS  = 25,
    parameter int T_HZ_NS  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we_req,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_drive,
    input  logic [DW-1:0] mem_dq_in
);
    // R9: window lengths in cycles
    localparam int RD_CYC   = imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                   imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
    localparam int HZ_CYC   = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int DS_CYC   = ns_to_cyc(T_DS_NS, CLK_NS);
    localparam int WP_CYC   = imax(ns_to_cyc(T_WP_NS, CLK_NS), HZ_CYC + DS_CYC);
    localparam int DATA_CYC = WP_CYC - HZ_CYC;
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC  = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 1;
    localparam int MAX_CYC  = imax(RD_CYC, imax(HZ_CYC, imax(DATA_CYC, REC_CYC)));
    localparam int CW       = $clog2(MAX_CYC + 1);

    sram_seq #(
        .AW(AW), .DW(DW), .CW(CW),
        .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .DATA_CYC(DATA_CYC),
        .REC_CYC(REC_CYC), .TURN_CYC(HZ_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we_req   (we_req),
        .addr     (addr),
        .wdata    (wdata),
        .dq_in    (mem_dq_in),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_out),
        .sel_n    (mem_sel_n),
        .sel      (mem_sel),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .drv      (mem_dq_drive)
    );

    assert_idle_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_drive));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n && mem_sel && !mem_dq_drive));

    assert_write_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_oe_n));

    assert_drive_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_drive);

    assert_drive_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_drive);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

    assert_done_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_sel_n && !mem_sel));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we_req = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #4 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we_req(we_req), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    typedef struct { bit wr; logic [7:0] data; } item_t;
    item_t       sbq[$];
    logic [7:0]  model_mem [int];
    logic [7:0]  exp_mem [int];

    // memory model: data appears only after the access time has elapsed
    int rd_age = 0;
    always @(posedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
    end

    int   cyc = 0, acc_cyc = 0, wrun = 0, orun = 0, gap = 0;
    bit   prev_busy = 0, prev_drv = 0, prev_sel = 0, seen_sel = 0, cur_wr = 0;
    logic [7:0] seen_data = '0;

    always @(negedge clk) begin
        bit s;
        cyc++;
        s = !mem_sel_n && mem_sel;
        if (s && !mem_oe_n && mem_we_n && rd_age >= 5)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
        if (rst_n) begin
            if (busy && !prev_busy) begin
                acc_cyc = cyc;
                cur_wr  = !mem_we_n || (s && mem_oe_n);
            end
            if (!mem_we_n) begin
                wrun++;
                if (mem_dq_drive) seen_data = mem_dq_out;
                if (mem_dq_drive && !prev_drv)
                    chk(wrun == 3, "R5", "drive rise after we fall", wrun, 3);
            end else if (wrun > 0) begin
                chk(wrun == 6, "R4", "we low length", wrun, 6);
                chk(!mem_dq_drive, "R5", "drive at we rise", mem_dq_drive, 0);
                model_mem[int'(mem_addr)] = seen_data;
                wrun = 0;
            end
            if (!mem_oe_n) orun++;
            else if (orun > 0) begin
                chk(orun == 6, "R3", "oe low length", orun, 6);
                orun = 0;
            end
            if (!s) gap++;
            else begin
                if (!prev_sel && seen_sel) chk(gap >= 1, "R7", "deselect gap", gap, 1);
                gap = 0;
                seen_sel = 1;
            end
            if (done) begin
                if (sbq.size() == 0) chk(0, "R2", "unexpected done", 1, 0);
                else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk((cyc - acc_cyc) == (it.wr ? 9 : 8), "R8", "done latency",
                        cyc - acc_cyc, it.wr ? 9 : 8);
                    if (!it.wr) chk(rdata === it.data, "R3", "read data", rdata, it.data);
                end
            end
            if (prev_busy == 0 && done) chk(0, "R8", "done without busy", 1, 0);
        end
        prev_busy = busy;
        prev_drv  = mem_dq_drive;
        prev_sel  = s;
    end

    task automatic issue(input bit w, input int a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; we_req = w; addr = 17'(a); wdata = d;
        it.wr = w;
        if (w) begin
            exp_mem[a] = d;
            it.data = d;
        end else begin
            it.data = exp_mem.exists(a) ? exp_mem[a] : 8'h00;
        end
        sbq.push_back(it);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_drive && !busy && !done,
            "R1", "reset strobes", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_drive, busy}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_sel_n && !mem_sel && !busy, "R1", "idle after reset", {mem_sel_n, mem_sel, busy}, 3'b100);

        // boundary addresses and corner bytes
        issue(1, 0, 8'h00);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(1, 17'h0AAAA, 8'hA5);
        issue(1, 17'h15555, 8'h5A);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 0, 8'h00);
        issue(0, 17'h15555, 8'h00);
        issue(0, 17'h0AAAA, 8'h00);

        // R2: req held while busy must be ignored
        issue(1, 17'h00100, 8'h3C);
        req = 1'b1; we_req = 1'b1; addr = 17'h00200; wdata = 8'hC3;
        repeat (3) @(negedge clk);
        req = 1'b0;
        issue(0, 17'h00200, 8'h00);
        issue(0, 17'h00100, 8'h00);

        // overwrite then read, read-after-write pairs
        issue(1, 17'h00010, 8'h11);
        issue(1, 17'h00010, 8'h22);
        issue(0, 17'h00010, 8'h00);
        for (int i = 0; i < 16; i++) issue(1, 17'h1000 + i, 8'(i * 37 + 5));
        for (int i = 0; i < 16; i++) issue(0, 17'h1000 + i, 8'h00);
        for (int i = 0; i < 4; i++) begin
            issue(1, 17'h1F000 + i * 3, 8'(8'h80 >> i));
            issue(0, 17'h1F000 + i * 3, 8'h00);
        end

        @(negedge clk);
        while (busy || sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R8", "all accesses completed", sbq.size(), 0);
        chk(mem_sel_n && !mem_sel && !busy, "R1", "idle at end", {mem_sel_n, mem_sel, busy}, 3'b100);
        finish_run();
    end
endmodule